// File: doc/BRIEF.md
# Prioritized Bus Error Aggregator

This block gathers error events from four processor bus ports (two data-read ports, one data-write port and one instruction-fetch port) and keeps a separate sticky flag register for each port. Every port accepts two 12-bit one-hot error-type vectors: one from the processor side and one from the memory side. The memory side defines only the acknowledge-error and uncorrectable-error types. Because each port has its own flags, software can find the faulting port by reading them back. It clears flags by writing ones to the bit positions it wants cleared.

Each flag has a fixed severity class that cannot be reprogrammed. Two types are low priority: the correctable memory error and the stack-pointer warning. All other types are high priority. The flags of each class are merged within a port and then across all four ports. The result is two registered level outputs for a downstream error-signaling controller: one for high priority and one for low priority. The controller therefore needs only two response settings, not one per event per bus.

Top module: `bus_err_aggregator`

## Requirements
- R1: After reset every flag of every bus reads 0, and both `hp_err_o` and `lp_err_o` are low.
- R2: Bus n uses bits [n*12 +: 12] of `core_err_i`, `mem_err_i` and the flag space. Bus 0 is data-read A, bus 1 is data-read B, bus 2 is data-write and bus 3 is instruction fetch. A processor-side event on type bit b of bus n sets flag bit b of bus n and no other flag. The type bits, from bit 0 upward, are: security-boundary violation, secure entry, secure exit, stack-pointer maximum, access timeout, acknowledge error, uncorrectable, correctable, stack-pointer warning, software breakpoint, illegal instruction, instruction timeout.
- R3: A memory-side event sets a flag only at bit 5 (acknowledge error) or bit 6 (uncorrectable). All other memory-side bits are reserved and have no effect on flags or outputs.
- R4: Flag bits 7 and 8 are low priority and drive only `lp_err_o`. Bits 0–6 and 9–11 are high priority and drive only `hp_err_o`.
- R5: A flag stays set after its input event goes away, until it is cleared.
- R6: When `clr_en_i` is high, every flag of the bus selected by `clr_sel_i` whose `clr_mask_i` bit is 1 is cleared at the next clock edge. Unmasked bits and other buses are unaffected.
- R7: If a set and a clear hit the same flag bit in the same cycle, the flag ends up set.
- R8: Each output goes high on the clock edge that captures a contributing event, one cycle after the input is presented. It stays high while any flag of its class is set and falls on the edge that clears the last one.
- R9: Events presented at the same time on any mix of types and buses are all captured in the same cycle.
- R10: `rd_flags_o` shows the current flags of the bus selected by `rd_sel_i`, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_err_i | input | 48 | Processor-side one-hot error types, 12 bits per bus |
| mem_err_i | input | 48 | Memory-side error types, 12 bits per bus (only bits 5 and 6 are defined) |
| clr_en_i | input | 1 | Clear strobe |
| clr_sel_i | input | 2 | Bus whose flags are cleared |
| clr_mask_i | input | 12 | Write-1-to-clear bit mask |
| rd_sel_i | input | 2 | Bus whose flags are read |
| rd_flags_o | output | 12 | Flags of the selected bus |
| hp_err_o | output | 1 | Aggregated high-priority error level |
| lp_err_o | output | 1 | Aggregated low-priority error level |

## Verification
The bench builds the block with its default four buses. It runs a full sweep over every bus, every type bit and both source sides, which covers all 96 single-event cases. Each case checks capture, reserved-bit masking and the class of the resulting output, then confirms the flag persists and clears cleanly. Added directed cases cover set-versus-clear in the same cycle, clears aimed at the wrong bus, partial masks, and all 48 bits raised at once.

// File: rtl/err_agg_pkg.sv
// Shared constants and types for the bus error aggregator.
// Assumes a fixed 12-bit one-hot error-type space per bus.
package err_agg_pkg;
    localparam int TYPE_W      = 12;
    localparam int NUM_BUS_DEF = 4;

    typedef logic [TYPE_W-1:0] etype_t;

    // Severity class is fixed in hardware per type bit.
    localparam etype_t LP_CLASS = 12'h180;
    // Types defined on the processor side and on the memory side.
    localparam etype_t CORE_DEF = 12'hFFF;
    localparam etype_t MEM_DEF  = 12'h060;
    localparam etype_t HP_CLASS = CORE_DEF & ~LP_CLASS;

    typedef struct packed {
        logic hp;
        logic lp;
    } cls_t;
endpackage

// File: rtl/err_src_mask.sv
// Merges one bus's processor-side and memory-side error vectors into a set
// vector, with reserved positions forced to zero. Purely combinational.
module err_src_mask
    import err_agg_pkg::*;
(
    input  etype_t core_i,
    input  etype_t mem_i,
    output etype_t set_o
);
    // Keep only defined types from each side, then merge them.
    always_comb begin
        set_o = (core_i & CORE_DEF) | (mem_i & MEM_DEF);
    end
endmodule

// File: rtl/err_flag_reg.sv
// Sticky write-1-to-clear flag register for one bus. A set has priority
// over a clear of the same bit. The next-state value is exported so that
// downstream registers can follow the flags with no added latency.
module err_flag_reg
    import err_agg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  etype_t set_i,
    input  etype_t clr_i,
    output etype_t flags_d_o,
    output etype_t flags_q_o
);
    etype_t flags_q;

    // Next state: clear the requested bits, then apply sets (sets win).
    always_comb begin
        flags_d_o = (flags_q & ~clr_i) | set_i;
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d_o;
    end

    assign flags_q_o = flags_q;
endmodule

// File: rtl/err_class_split.sv
// Reduces one bus's flags into a high-priority and a low-priority bit
// using the fixed class masks. Purely combinational.
module err_class_split
    import err_agg_pkg::*;
(
    input  etype_t flags_i,
    output cls_t   cls_o
);
    // OR-reduce each severity class separately.
    always_comb begin
        cls_o.hp = |(flags_i & HP_CLASS);
        cls_o.lp = |(flags_i & LP_CLASS);
    end
endmodule

// File: rtl/bus_err_aggregator.sv
// Top level: per-bus sticky error flags, a clear and read port, and two
// registered aggregate outputs split by severity class. Assumes clear and
// read selects are synchronous to clk; reset is synchronous, active low.
module bus_err_aggregator
    import err_agg_pkg::*;
#(
    parameter int NUM_BUS = NUM_BUS_DEF,
    localparam int SEL_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
    localparam int FLAT_W = NUM_BUS * TYPE_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAT_W-1:0] core_err_i,
    input  logic [FLAT_W-1:0] mem_err_i,
    input  logic              clr_en_i,
    input  logic [SEL_W-1:0]  clr_sel_i,
    input  logic [TYPE_W-1:0] clr_mask_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [TYPE_W-1:0] rd_flags_o,
    output logic              hp_err_o,
    output logic              lp_err_o
);
    etype_t              flag_q_arr [NUM_BUS];
    logic [FLAT_W-1:0]   flag_q_all;
    logic [NUM_BUS-1:0]  hp_vec;
    logic [NUM_BUS-1:0]  lp_vec;
    logic                hp_q;
    logic                lp_q;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        etype_t set_v;
        etype_t clr_v;
        etype_t flags_d;
        cls_t   cls;

        err_src_mask u_mask (
            .core_i (core_err_i[b*TYPE_W +: TYPE_W]),
            .mem_i  (mem_err_i[b*TYPE_W +: TYPE_W]),
            .set_o  (set_v)
        );

        // Route the clear mask only to the selected bus.
        always_comb begin
            clr_v = (clr_en_i && (clr_sel_i == SEL_W'(b))) ? clr_mask_i : '0;
        end

        err_flag_reg u_flags (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_v),
            .clr_i     (clr_v),
            .flags_d_o (flags_d),
            .flags_q_o (flag_q_arr[b])
        );

        err_class_split u_split (
            .flags_i (flags_d),
            .cls_o   (cls)
        );

        assign hp_vec[b] = cls.hp;
        assign lp_vec[b] = cls.lp;
        assign flag_q_all[b*TYPE_W +: TYPE_W] = flag_q_arr[b];
    end

    // Aggregate outputs register the next-state class levels across buses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_q <= 1'b0;
            lp_q <= 1'b0;
        end else begin
            hp_q <= |hp_vec;
            lp_q <= |lp_vec;
        end
    end

    // Read port: select one bus's current flags.
    always_comb begin
        rd_flags_o = '0;
        for (int b = 0; b < NUM_BUS; b++) begin
            if (rd_sel_i == SEL_W'(b)) rd_flags_o = flag_q_arr[b];
        end
    end

    assign hp_err_o = hp_q;
    assign lp_err_o = lp_q;
endmodule

// File: rtl/err_agg_chk.sv
// Assertion checker for bus_err_aggregator, attached by bind. It derives
// the expected set and clear vectors from the ports and checks the flag
// state and the outputs against them.
module err_agg_chk
    import err_agg_pkg::*;
#(
    parameter int NUM_BUS = NUM_BUS_DEF,
    localparam int SEL_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
    localparam int FLAT_W = NUM_BUS * TYPE_W
)(
    input logic              clk,
    input logic              rst_n,
    input logic [FLAT_W-1:0] core_err_i,
    input logic [FLAT_W-1:0] mem_err_i,
    input logic              clr_en_i,
    input logic [SEL_W-1:0]  clr_sel_i,
    input logic [TYPE_W-1:0] clr_mask_i,
    input logic [FLAT_W-1:0] flag_q_all,
    input logic              hp_err_o,
    input logic              lp_err_o
);
    logic [FLAT_W-1:0] set_flat;
    logic [FLAT_W-1:0] clr_flat;
    logic [FLAT_W-1:0] hp_all;
    logic [FLAT_W-1:0] lp_all;

    // Expected set/clear vectors and class masks derived from the ports.
    always_comb begin
        set_flat = (core_err_i & {NUM_BUS{CORE_DEF}}) | (mem_err_i & {NUM_BUS{MEM_DEF}});
        clr_flat = '0;
        for (int b = 0; b < NUM_BUS; b++) begin
            if (clr_en_i && (clr_sel_i == SEL_W'(b)))
                clr_flat[b*TYPE_W +: TYPE_W] = clr_mask_i;
        end
        hp_all = {NUM_BUS{HP_CLASS}};
        lp_all = {NUM_BUS{LP_CLASS}};
    end

    // R9 and R7: every requested set is present after the edge.
    assert_set_captured_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flat != '0) |=> ((flag_q_all & $past(set_flat)) == $past(set_flat)));

    // R5 and R6: a flag drops only when its clear bit was written.
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~flag_q_all & $past(flag_q_all) & ~$past(clr_flat)) == '0));

    // R3: a flag rises only from a defined, unmasked source bit.
    assert_no_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q_all & ~$past(flag_q_all) & ~$past(set_flat)) == '0));

    // R8: the high output tracks the high-class flags.
    assert_hp_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hp_err_o == (|(flag_q_all & hp_all)));

    // R4: the low output tracks the low-class flags.
    assert_lp_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lp_err_o == (|(flag_q_all & lp_all)));
endmodule

bind bus_err_aggregator err_agg_chk #(.NUM_BUS(NUM_BUS)) u_chk (.*);

// File: tb/tb_bus_err_aggregator.sv
// Self-checking bench: exhaustive single-event sweep plus directed corners.
module tb_bus_err_aggregator;
    localparam int NB = 4;
    localparam int TW = 12;
    localparam logic [TW-1:0] LPM  = 12'h180;
    localparam logic [TW-1:0] HPM  = 12'hE7F;
    localparam logic [TW-1:0] MEMM = 12'h060;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB*TW-1:0] core_err = '0;
    logic [NB*TW-1:0] mem_err  = '0;
    logic clr_en = 1'b0;
    logic [1:0] clr_sel = '0;
    logic [TW-1:0] clr_mask = '0;
    logic [1:0] rd_sel = '0;
    logic [TW-1:0] rd_flags;
    logic hp_err, lp_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [TW-1:0] model [NB];

    always #2 clk = ~clk;

    bus_err_aggregator dut (
        .clk(clk), .rst_n(rst_n), .core_err_i(core_err), .mem_err_i(mem_err),
        .clr_en_i(clr_en), .clr_sel_i(clr_sel), .clr_mask_i(clr_mask),
        .rd_sel_i(rd_sel), .rd_flags_o(rd_flags), .hp_err_o(hp_err), .lp_err_o(lp_err)
    );

    task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Compare every bus's flags and both outputs against the model.
    task automatic check_all(input string tag);
        logic [TW-1:0] any;
        any = '0;
        for (int b = 0; b < NB; b++) begin
            rd_sel = 2'(b);
            #1;
            chk({tag, " R10 rd"}, rd_flags, model[b]);
            any |= model[b];
        end
        chk({tag, " hp"}, {11'b0, hp_err}, {11'b0, |(any & HPM)});
        chk({tag, " lp"}, {11'b0, lp_err}, {11'b0, |(any & LPM)});
    endtask

    // Present inputs for one cycle at a negedge, update the model, then idle.
    task automatic apply(input logic [NB*TW-1:0] c, input logic [NB*TW-1:0] m,
                         input logic ce, input int sel, input logic [TW-1:0] msk);
        core_err = c; mem_err = m; clr_en = ce; clr_sel = 2'(sel); clr_mask = msk;
        for (int b = 0; b < NB; b++) begin
            logic [TW-1:0] s, k;
            s = c[b*TW +: TW] | (m[b*TW +: TW] & MEMM);
            k = (ce && sel == b) ? msk : '0;
            model[b] = (model[b] & ~k) | s;
        end
        @(posedge clk); @(negedge clk);
        core_err = '0; mem_err = '0; clr_en = 1'b0; clr_mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) model[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // Exhaustive single-event sweep: bus x type bit x source side.
        for (int b = 0; b < NB; b++) begin
            for (int t = 0; t < TW; t++) begin
                for (int side = 0; side < 2; side++) begin
                    logic [NB*TW-1:0] v;
                    v = '0;
                    v[b*TW + t] = 1'b1;
                    if (side == 0) apply(v, '0, 1'b0, 0, '0);
                    else           apply('0, v, 1'b0, 0, '0);
                    check_all(side == 0 ? "R2 R4 R8 core event" : "R3 R4 mem event");
                    @(negedge clk);
                    check_all("R5 sticky");
                    apply('0, '0, 1'b1, b, 12'hFFF);
                    check_all("R6 R8 clear");
                end
            end
        end

        // Set and clear on the same bit in the same cycle: set wins.
        apply({12'h0, 12'h0, 12'h008, 12'h0}, '0, 1'b0, 0, '0);
        apply({12'h0, 12'h0, 12'h008, 12'h0}, '0, 1'b1, 1, 12'h008);
        check_all("R7 set wins");
        chk("R7 bus1 bit3", model[1], 12'h008);

        // Clear aimed at another bus leaves bus 1 untouched.
        apply('0, '0, 1'b1, 2, 12'hFFF);
        check_all("R6 other bus");

        // Partial clear keeps the unmasked bits.
        apply({12'h0, 12'h0, 12'h180, 12'h0}, '0, 1'b0, 0, '0);
        apply('0, '0, 1'b1, 1, 12'h088);
        check_all("R6 partial");
        chk("R6 bus1 remains", model[1], 12'h100);
        apply('0, '0, 1'b1, 1, 12'hFFF);
        check_all("R8 all clear");

        // Every bit on every bus at once.
        apply({NB*TW{1'b1}}, {NB*TW{1'b1}}, 1'b0, 0, '0);
        check_all("R9 simultaneous");
        for (int b = 0; b < NB; b++) apply('0, '0, 1'b1, b, 12'h180);
        check_all("R4 only high left");
        for (int b = 0; b < NB; b++) apply('0, '0, 1'b1, b, 12'hFFF);
        check_all("R8 drained");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule